// File: doc/BRIEF.md
# Parallel EEPROM Write Sequencer

This block is the control logic of a byte-wide parallel EEPROM, modelled as synchronous logic on a fast sample clock. The chip-enable, write-enable and output-enable pins (all active low), the address and the data input are passed through two flip-flop stages. The synchronised pins are then decoded into read and write windows. A write window exists while chip enable and write enable are both low and output enable is high. Its start is the later of the two falling strobe edges, so the address is taken there. Its end is the earlier of the two rising edges, so the data is taken there. A window shorter than a minimum number of sample clocks is discarded.

Each accepted byte goes into a small page buffer. When a window ends, a byte-load timer starts. It pauses while the next window is open, and an accepted byte restarts it. When the timer runs out, the internal program cycle starts: the block reports busy, ignores write strobes and keeps serving reads from the old contents. At the end of the cycle the whole buffer is written into the storage array in one step. After reset, a power-up interval also reports busy and inhibits writes. The data output is enabled only for a read, which needs chip enable and output enable low and write enable high.

The sequencer has four states. ST_PWRUP is the power-up write inhibit. ST_IDLE waits for a first byte. ST_LOAD collects bytes while the byte-load timer runs. ST_PROG is the program cycle. There are five transitions:
- ST_PWRUP to ST_IDLE when the power-up count ends.
- ST_IDLE to ST_LOAD on an accepted byte.
- ST_LOAD to ST_LOAD on each further byte, which restarts the timer.
- ST_LOAD to ST_PROG when the timer expires.
- ST_PROG to ST_IDLE when the program count ends, which commits the buffer.

Top module: `eewr_seq`

## Requirements
- R1: After reset, busy is 1 for PWRUP_CYC clocks. A write strobe that ends within that interval changes no stored byte.
- R2: Two clocks after the pins show ce_n=0, oe_n=0, we_n=1, dout_en is 1 and dout carries the stored byte at the synchronised address. In every other case dout_en is 0 and dout is 0.
- R3: With ce_n=1, write-enable pulses store nothing, start no program cycle and leave dout_en at 0.
- R4: A write window needs ce_n=0, we_n=0 and oe_n=1 at the same time. A strobe with oe_n=0 stores nothing and leaves busy at 0.
- R5: The address is the one present when the later of ce_n/we_n falls. The data is the one present on the last sample before the earlier of the two rises. This holds for both the WE-controlled and the CE-controlled order.
- R6: A window shorter than MIN_PULSE (4) sample clocks is ignored. A window of exactly MIN_PULSE clocks is accepted.
- R7: The program cycle begins BLC_CYC clocks after the last accepted window ends. A new window that opens before then pauses the timer, its acceptance restarts it, and busy stays 0 while a page is loading.
- R8: busy is 1 for PROG_CYC clocks during the program cycle. Write strobes during this time are ignored. Reads return the previous contents, and the new bytes are readable once busy falls.
- R9: The page buffer holds PAGE_N (4) bytes, and further bytes in the same page are dropped. Bytes are committed in load order, so a later byte to the same address wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| addr | input | AW | Byte address pins |
| din | input | DW | Data pins, input direction |
| dout | output | DW | Data pins, output direction (0 when not enabled) |
| dout_en | output | 1 | Output driver enable for the data pins |
| busy | output | 1 | Power-up inhibit or program cycle in progress |

## Verification
The assertions assume that the pins are sampled only at clock edges and that address and data stay stable while a strobe edge passes through the synchroniser. They also assume that a write strobe never straddles the end of the power-up interval or the end of a program cycle. The bench drives every pin on the falling clock edge, so each level is held for whole sample clocks. It waits out the power-up and program counts with margin before issuing writes that are meant to be accepted. It also places its deliberately ignored writes well inside those intervals.

// File: rtl/eewr_pkg.sv
`timescale 1ns/1ps
package eewr_pkg;
    typedef enum logic [1:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_LOAD,
        ST_PROG
    } seq_state_t;
endpackage

// File: rtl/eewr_sync.sv
`timescale 1ns/1ps
// Two-stage synchroniser for a bundle of pins.
module eewr_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/eewr_strobe.sv
`timescale 1ns/1ps
// Tracks the write window: address at its opening, data at its last sample,
// and a width count that filters short strobes.
module eewr_strobe #(
    parameter int AW        = 3,
    parameter int DW        = 8,
    parameter int MIN_PULSE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_act,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          load_vld,
    output logic [AW-1:0] load_addr,
    output logic [DW-1:0] load_data
);
    localparam int LW = $clog2(MIN_PULSE + 1);

    logic          act_q;
    logic [LW-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q     <= 1'b0;
            len_q     <= '0;
            load_addr <= '0;
            load_data <= '0;
        end else begin
            act_q <= wr_act;
            if (wr_act) begin
                load_data <= data_s;
                if (!act_q) begin
                    load_addr <= addr_s;
                    len_q     <= LW'(1);
                end else if (len_q != LW'(MIN_PULSE)) begin
                    len_q <= len_q + 1'b1;
                end
            end
        end
    end

    assign load_vld = act_q & ~wr_act & (len_q >= LW'(MIN_PULSE));
endmodule

// File: rtl/eewr_pagebuf.sv
`timescale 1ns/1ps
// Page buffer plus storage array; commit copies all loaded slots in order.
module eewr_pagebuf #(
    parameter int AW     = 3,
    parameter int DW     = 8,
    parameter int PAGE_N = 4,
    parameter int FW     = $clog2(PAGE_N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          commit,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [FW-1:0] fill
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem     [DEPTH];
    logic [AW-1:0] slot_a  [PAGE_N];
    logic [DW-1:0] slot_d  [PAGE_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            for (int i = 0; i < PAGE_N; i++) begin
                slot_a[i] <= '0;
                slot_d[i] <= '0;
            end
        end else if (commit) begin
            for (int i = 0; i < PAGE_N; i++) begin
                if (FW'(i) < fill) mem[slot_a[i]] <= slot_d[i];
            end
            fill <= '0;
        end else if (push && fill < FW'(PAGE_N)) begin
            for (int i = 0; i < PAGE_N; i++) begin
                if (fill == FW'(i)) begin
                    slot_a[i] <= push_addr;
                    slot_d[i] <= push_data;
                end
            end
            fill <= fill + 1'b1;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eewr_seq.sv
`timescale 1ns/1ps
module eewr_seq
    import eewr_pkg::*;
#(
    parameter int AW        = 3,
    parameter int DW        = 8,
    parameter int PAGE_N    = 4,
    parameter int MIN_PULSE = 4,
    parameter int BLC_CYC   = 16,
    parameter int PROG_CYC  = 40,
    parameter int PWRUP_CYC = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          busy
);
    localparam int FW     = $clog2(PAGE_N + 1);
    localparam int MAX_AB = (PWRUP_CYC > BLC_CYC) ? PWRUP_CYC : BLC_CYC;
    localparam int MAX_C  = (MAX_AB > PROG_CYC) ? MAX_AB : PROG_CYC;
    localparam int CNTW   = $clog2(MAX_C + 1);

    logic          ce_s, we_s, oe_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] din_s;
    logic          wr_act, rd_act;
    logic          load_vld;
    logic [AW-1:0] load_addr;
    logic [DW-1:0] load_data;
    logic          do_push, do_commit;
    logic [DW-1:0] rd_data;
    logic [FW-1:0] pb_fill;
    logic [CNTW-1:0] cnt;
    logic          cnt_clr, cnt_inc;
    seq_state_t    state, state_nxt;

    eewr_sync #(.W(3), .RST_VAL(3'b111)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ce_n, we_n, oe_n}), .q({ce_s, we_s, oe_s})
    );

    eewr_sync #(.W(AW + DW), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n),
        .d({addr, din}), .q({addr_s, din_s})
    );

    assign wr_act = ~ce_s & ~we_s & oe_s;
    assign rd_act = ~ce_s & ~oe_s & we_s;

    eewr_strobe #(.AW(AW), .DW(DW), .MIN_PULSE(MIN_PULSE)) u_strobe (
        .clk(clk), .rst_n(rst_n), .wr_act(wr_act),
        .addr_s(addr_s), .data_s(din_s),
        .load_vld(load_vld), .load_addr(load_addr), .load_data(load_data)
    );

    eewr_pagebuf #(.AW(AW), .DW(DW), .PAGE_N(PAGE_N), .FW(FW)) u_pagebuf (
        .clk(clk), .rst_n(rst_n),
        .push(do_push), .push_addr(load_addr), .push_data(load_data),
        .commit(do_commit), .rd_addr(addr_s), .rd_data(rd_data), .fill(pb_fill)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWRUP;
        else        state <= state_nxt;
    end

    // Shared interval counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (cnt_clr) cnt <= '0;
        else if (cnt_inc) cnt <= cnt + 1'b1;
    end

    // Next state and sequencing controls
    always_comb begin
        state_nxt = state;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        do_push   = 1'b0;
        do_commit = 1'b0;
        unique case (state)
            ST_PWRUP: begin
                if (cnt == CNTW'(PWRUP_CYC - 1)) begin
                    state_nxt = ST_IDLE;
                    cnt_clr   = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_IDLE: begin
                if (load_vld) begin
                    do_push   = 1'b1;
                    cnt_clr   = 1'b1;
                    state_nxt = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (load_vld) begin
                    do_push = 1'b1;
                    cnt_clr = 1'b1;
                end else if (!wr_act) begin
                    if (cnt == CNTW'(BLC_CYC - 1)) begin
                        state_nxt = ST_PROG;
                        cnt_clr   = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (cnt == CNTW'(PROG_CYC - 1)) begin
                    do_commit = 1'b1;
                    cnt_clr   = 1'b1;
                    state_nxt = ST_IDLE;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: state_nxt = ST_PWRUP;
        endcase
    end

    // Outputs
    always_comb begin
        busy    = (state == ST_PWRUP) || (state == ST_PROG);
        dout_en = rd_act;
        dout    = rd_act ? rd_data : '0;
    end
endmodule

// File: rtl/eewr_seq_chk.sv
`timescale 1ns/1ps
module eewr_seq_chk #(
    parameter int DW     = 8,
    parameter int FW     = 3,
    parameter int PAGE_N = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          we_n,
    input logic          oe_n,
    input logic [DW-1:0] dout,
    input logic          dout_en,
    input logic          busy,
    input logic [FW-1:0] fill,
    input logic          commit
);
    assert_drive_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!ce_n && !oe_n && we_n, 2));

    assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout == '0);

    assert_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n, 2) |-> !dout_en);

    assert_prog_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> fill != '0);

    assert_commit_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);

    assert_no_load_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> $stable(fill));

    assert_commit_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (fill == '0) && !busy);

    assert_page_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(PAGE_N));
endmodule

bind eewr_seq eewr_seq_chk #(.DW(DW), .FW(FW), .PAGE_N(PAGE_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .dout(dout), .dout_en(dout_en), .busy(busy),
    .fill(pb_fill), .commit(do_commit)
);

// File: tb/sim_eewr_seq.sv
`timescale 1ns/1ps
module sim_eewr_seq;
    localparam int AW = 3, DW = 8, PAGE_N = 4, MIN_PULSE = 4;
    localparam int BLC_CYC = 16, PROG_CYC = 40, PWRUP_CYC = 24;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_en, busy;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit started = 0;

    always #2.5 clk = ~clk;

    eewr_seq #(.AW(AW), .DW(DW), .PAGE_N(PAGE_N), .MIN_PULSE(MIN_PULSE),
               .BLC_CYC(BLC_CYC), .PROG_CYC(PROG_CYC), .PWRUP_CYC(PWRUP_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0h expected %0h at %0t", rq, what, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct packed {
        logic ce, we, oe;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } pins_t;
    localparam pins_t IDLE_PINS = '{ce: 1'b1, we: 1'b1, oe: 1'b1, a: '0, d: '0};

    pins_t h1 = IDLE_PINS, h2 = IDLE_PINS;
    logic [DW-1:0] mmem [DEPTH];
    logic [AW-1:0] qa [$];
    logic [DW-1:0] qd [$];
    int m_st = 0;          // 0 power-up, 1 idle, 2 loading, 3 programming
    int m_cnt = 0;
    bit m_wprev = 0;
    int m_wlen = 0;
    logic [AW-1:0] m_al = '0;
    logic [DW-1:0] m_dl = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = IDLE_PINS; h2 = IDLE_PINS;
            for (int i = 0; i < DEPTH; i++) mmem[i] = '0;
            qa.delete(); qd.delete();
            m_st = 0; m_cnt = 0; m_wprev = 0; m_wlen = 0; m_al = '0; m_dl = '0;
        end else begin
            pins_t cur;
            bit w, ended;
            cur = '{ce: ce_n, we: we_n, oe: oe_n, a: addr, d: din};
            w = !h2.ce && !h2.we && h2.oe;
            ended = !w && m_wprev && (m_wlen >= MIN_PULSE);
            case (m_st)
                0: begin
                    if (m_cnt == PWRUP_CYC - 1) begin m_st = 1; m_cnt = 0; end
                    else m_cnt++;
                end
                1: if (ended) begin
                    if (qa.size() < PAGE_N) begin qa.push_back(m_al); qd.push_back(m_dl); end
                    m_st = 2; m_cnt = 0;
                end
                2: begin
                    if (ended) begin
                        if (qa.size() < PAGE_N) begin qa.push_back(m_al); qd.push_back(m_dl); end
                        m_cnt = 0;
                    end else if (!w) begin
                        if (m_cnt == BLC_CYC - 1) begin m_st = 3; m_cnt = 0; end
                        else m_cnt++;
                    end
                end
                default: begin
                    if (m_cnt == PROG_CYC - 1) begin
                        foreach (qa[i]) mmem[qa[i]] = qd[i];
                        qa.delete(); qd.delete();
                        m_st = 1; m_cnt = 0;
                    end else m_cnt++;
                end
            endcase
            if (w) begin
                m_dl = h2.d;
                if (!m_wprev) begin m_al = h2.a; m_wlen = 1; end
                else if (m_wlen < MIN_PULSE) m_wlen++;
            end
            m_wprev = w;
            h2 = h1;
            h1 = cur;
        end
    end

    // Per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && started) begin
            bit e_en, e_busy;
            logic [DW-1:0] e_do;
            e_en = !h2.ce && !h2.oe && h2.we;
            e_do = e_en ? mmem[h2.a] : '0;
            e_busy = (m_st == 0) || (m_st == 3);
            chk(dout_en == e_en, tag, "model dout_en", int'(dout_en), int'(e_en));
            chk(dout == e_do, tag, "model dout", int'(dout), int'(e_do));
            chk(busy == e_busy, tag, "model busy", int'(busy), int'(e_busy));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic go_idle(input int n);
        @(negedge clk);
        ce_n = 1; we_n = 1; oe_n = 1;
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string rq);
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        repeat (3) @(negedge clk);
        chk(dout_en == 1'b1, rq, "read dout_en", int'(dout_en), 1);
        chk(dout == exp, rq, "read data", int'(dout), int'(exp));
        ce_n = 1; oe_n = 1;
    endtask

    // ce_ctl=0: WE-controlled; ce_ctl=1: CE-controlled
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int width, input bit ce_ctl);
        @(negedge clk);
        oe_n = 1; addr = ~a; din = ~d;
        if (ce_ctl) begin ce_n = 1; we_n = 0; end
        else begin ce_n = 0; we_n = 1; end
        @(negedge clk);
        addr = a;
        if (ce_ctl) ce_n = 0; else we_n = 0;
        @(negedge clk);
        addr = ~a; din = d;
        repeat (width - 1) @(negedge clk);
        din = ~d;
        if (ce_ctl) ce_n = 1; else we_n = 1;
        @(negedge clk);
        ce_n = 1; we_n = 1;
    endtask

    task automatic wait_busy(input bit lvl, input int limit, input string rq);
        int n = 0;
        while (busy != lvl && n < limit) begin @(negedge clk); n++; end
        chk(busy == lvl, rq, "busy level reached", int'(busy), int'(lvl));
    endtask

    // ---------------- main sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        started = 1;
        @(negedge clk);
        tag = "R1";
        chk(busy == 1'b1, "R1", "busy after reset", int'(busy), 1);
        chk(dout_en == 1'b0, "R1", "dout_en after reset", int'(dout_en), 0);
        wr(3'd1, 8'hAA, 5, 0);              // inside power-up: ignored
        go_idle(PWRUP_CYC + 4);
        chk(busy == 1'b0, "R1", "busy after power-up", int'(busy), 0);
        rd(3'd1, 8'h00, "R1");

        tag = "R2";
        rd(3'd0, 8'h00, "R2");
        @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1;
        repeat (3) @(negedge clk);
        chk(dout_en == 1'b0, "R2", "no drive with oe_n high", int'(dout_en), 0);
        go_idle(2);

        tag = "R5";
        wr(3'd2, 8'h5A, 5, 0);
        go_idle(BLC_CYC + PROG_CYC + 6);
        rd(3'd2, 8'h5A, "R5");
        wr(3'd3, 8'hC3, 5, 1);
        go_idle(BLC_CYC + PROG_CYC + 6);
        rd(3'd3, 8'hC3, "R5");

        tag = "R4";
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 0; addr = 3'd4; din = 8'h44;
        repeat (6) @(negedge clk);
        go_idle(BLC_CYC + 6);
        chk(busy == 1'b0, "R4", "no program after oe_n low strobe", int'(busy), 0);
        rd(3'd4, 8'h00, "R4");

        tag = "R3";
        @(negedge clk); ce_n = 1; oe_n = 1; we_n = 0; addr = 3'd5; din = 8'h55;
        repeat (6) @(negedge clk);
        we_n = 1; oe_n = 0;
        repeat (3) @(negedge clk);
        chk(dout_en == 1'b0, "R3", "standby keeps bus off", int'(dout_en), 0);
        go_idle(BLC_CYC + 6);
        chk(busy == 1'b0, "R3", "standby strobe starts nothing", int'(busy), 0);
        rd(3'd5, 8'h00, "R3");

        tag = "R6";
        wr(3'd6, 8'h99, MIN_PULSE - 1, 0);
        go_idle(BLC_CYC + 6);
        chk(busy == 1'b0, "R6", "short strobe ignored", int'(busy), 0);
        rd(3'd6, 8'h00, "R6");
        wr(3'd6, 8'h66, MIN_PULSE, 0);
        go_idle(BLC_CYC + PROG_CYC + 6);
        rd(3'd6, 8'h66, "R6");

        tag = "R7";
        wr(3'd0, 8'h10, 5, 0);
        chk(busy == 1'b0, "R7", "busy low during page load", int'(busy), 0);
        wr(3'd1, 8'h21, 6, 1);
        chk(busy == 1'b0, "R7", "busy low during page load", int'(busy), 0);
        wr(3'd7, 8'h7E, 5, 0);
        chk(busy == 1'b0, "R7", "busy low during page load", int'(busy), 0);
        wait_busy(1'b1, BLC_CYC + 8, "R7");
        wait_busy(1'b0, PROG_CYC + 8, "R7");
        go_idle(2);
        rd(3'd0, 8'h10, "R7");
        rd(3'd1, 8'h21, "R7");
        rd(3'd7, 8'h7E, "R7");

        tag = "R8";
        wr(3'd2, 8'h77, 5, 0);
        wait_busy(1'b1, BLC_CYC + 8, "R8");
        rd(3'd2, 8'h5A, "R8");               // old value while programming
        wr(3'd3, 8'h11, 5, 0);               // ignored while busy
        wait_busy(1'b0, PROG_CYC + 8, "R8");
        go_idle(BLC_CYC + 6);
        chk(busy == 1'b0, "R8", "ignored strobe starts nothing", int'(busy), 0);
        rd(3'd2, 8'h77, "R8");
        rd(3'd3, 8'hC3, "R8");

        tag = "R9";
        wr(3'd4, 8'h41, 5, 0);
        wr(3'd4, 8'h42, 5, 1);
        wr(3'd5, 8'h55, 5, 0);
        wr(3'd6, 8'h69, 5, 0);
        wr(3'd7, 8'h70, 5, 0);               // fifth byte: dropped
        wait_busy(1'b1, BLC_CYC + 8, "R9");
        wait_busy(1'b0, PROG_CYC + 8, "R9");
        go_idle(2);
        rd(3'd4, 8'h42, "R9");
        rd(3'd5, 8'h55, "R9");
        rd(3'd6, 8'h69, "R9");
        rd(3'd7, 8'h7E, "R9");

        go_idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog %s got timeout expected completion", tag);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule